// File: doc/BRIEF.md
# Serial Character Receiver with Error Queue and Idle Timeout

This block recovers asynchronous serial characters from a single input line. The line is first brought into the clock domain by a two-stage synchronizer. It is then sampled on cycles where a sixteen-times-bit-rate clock enable is high. The character format is set at run time: word length, parity mode and stop length. Each recovered byte goes into a small receive queue together with four error flags. The head of the queue is visible at the outputs, and a read strobe removes it.

A queue-wide error output shows whether any stored character is flagged. A free-running ten-bit idle counter counts enable ticks since the last start bit or read. From it, a timeout flag is raised when characters are waiting but no new activity has arrived for a time that scales with the word length. With the queue disabled, the block acts as a single holding register. A clear input discards everything stored.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, `empty` is 1, `q_count` is 0, `err_any` is 0, `rx_timeout` is 0 and `idle_cnt` is 0.
- R2: `data_bits` selects 5 to 8 data bits, received least significant bit first; `rd_data` holds them right-aligned with the unused upper bits zero.
- R3: `parity_mode` bit 0 enables a parity bit after the data. Bits [2:1] choose its expected value: 00 odd (code 001), 01 even (011), 10 always 1 (101), 11 always 0 (111). `rd_perr` is 1 when the received parity bit differs from the expected value, and is 0 when parity is disabled.
- R4: `stop_half` gives the stop length in half bits: 2 means one stop bit, 3 means one and a half, 4 means two. Each whole stop bit is sampled at its centre. `rd_ferr` is 1 if any stop sample is low.
- R5: When a character completes while the queue is full and no read occurs in that cycle, the new byte is dropped and the newest stored entry gets `rd_ovr` = 1. With `queue_en` = 0 the capacity is one entry.
- R6: Characters are read in arrival order. `q_count` gives the number stored (at most DEPTH), and `empty` is 1 exactly when it is 0. A read while empty has no effect.
- R7: `err_any` is 1 while at least one stored entry has any of its four flags set.
- R8: `rd_brk` is 1 when every data, parity and stop sample of the character was low; such a character also has `rd_ferr` = 1.
- R9: A falling edge starts reception only if the line is still low at the eighth tick; otherwise it is discarded and nothing is stored.
- R10: Sampling and the idle counter advance only on cycles with `tick16` = 1; with `tick16` held at 0 line activity is ignored.
- R11: `idle_cnt` increments on each tick and returns to 0 on a detected falling edge and on `rd_stb`. `rx_timeout` sets when `idle_cnt[9:4]` equals 4×`data_bits`+12 with the queue non-empty, and clears in the cycle after `rd_stb`.
- R12: `rx_timeout` never rises while the queue is empty.
- R13: `queue_clear` empties the queue: the cycle after, `q_count` is 0 and `empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sixteen-times bit-rate clock enable |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| data_bits | input | 4 | Word length, 5 to 8 |
| parity_mode | input | 3 | Parity code (see R3) |
| stop_half | input | 3 | Stop length in half bits, 2 to 4 |
| queue_en | input | 1 | 1: full queue, 0: single holding register |
| queue_clear | input | 1 | Discard all stored characters |
| rd_stb | input | 1 | Remove the head entry |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break |
| rd_ovr | output | 1 | Head entry overrun mark |
| empty | output | 1 | Queue empty |
| q_count | output | 4 | Stored entries |
| err_any | output | 1 | Any stored entry flagged |
| idle_cnt | output | 10 | Ticks since last start or read |
| rx_timeout | output | 1 | Idle timeout with data waiting |

## Verification
The assertions assume a configuration that holds still for the length of a frame. They also assume `data_bits` stays within 5 to 8, `parity_mode` takes one of the five listed codes, `stop_half` stays within 2 to 4, and `queue_en` changes only while the queue is empty. The stimulus sets the format, the queue mode and the tick rate only between frames, with the line idle high and the queue drained. Frames are generated from bit times that are whole multiples of the tick period. Tick gating is tested by holding `tick16` low across a whole stretch of line activity.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;

    localparam int unsigned TICKS_PER_BIT = 16;
    localparam int unsigned TCNT_W        = $clog2(TICKS_PER_BIT);
    localparam logic [TCNT_W-1:0] MID_TICK  = TCNT_W'(TICKS_PER_BIT / 2 - 1);
    localparam logic [TCNT_W-1:0] LAST_TICK = TCNT_W'(TICKS_PER_BIT - 1);
    localparam int unsigned IDLE_W        = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
        logic       ovr;
    } rx_char_t;

    // Right-align a byte shifted in from the top, n bits long.
    function automatic logic [7:0] align_data(input logic [7:0] sh, input logic [3:0] n);
        return sh >> (4'd8 - n);
    endfunction

    // Expected parity bit for the selected mode.
    function automatic logic parity_expect(input logic [7:0] d, input logic [2:0] mode);
        logic p;
        unique case (mode[2:1])
            2'b00:   p = ~(^d);
            2'b01:   p = ^d;
            2'b10:   p = 1'b1;
            default: p = 1'b0;
        endcase
        return p;
    endfunction

    // Number of whole stop bits sampled for a stop length in half bits.
    function automatic logic [1:0] stop_count(input logic [2:0] stop_half);
        return (stop_half >= 3'd4) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [5:0] idle_limit(input logic [3:0] data_bits);
        return {data_bits, 2'b00} + 6'd12;
    endfunction

endpackage

// File: rtl/srx_sync.sv
`timescale 1ns/1ps
module srx_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
`timescale 1ns/1ps
module srx_framer
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx_s,
    input  logic [3:0] data_bits,
    input  logic [2:0] parity_mode,
    input  logic [2:0] stop_half,
    output logic       start_det,
    output logic       push,
    output rx_char_t   char_out
);
    rx_state_e          state;
    logic [TCNT_W-1:0]  tcnt;
    logic [3:0]         bitn;
    logic [7:0]         sh;
    logic [1:0]         stop_left;
    logic               par_bit, ferr, all_low, line_prev;

    logic [7:0] aligned;
    logic       par_exp, samp_pt, ferr_n, low_n;

    always_comb begin
        aligned = align_data(sh, data_bits);
        par_exp = parity_expect(aligned, parity_mode);
        samp_pt = (tcnt == LAST_TICK);
        ferr_n  = ferr | ~rx_s;
        low_n   = all_low & ~rx_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            tcnt      <= '0;
            bitn      <= '0;
            sh        <= '0;
            stop_left <= '0;
            par_bit   <= 1'b0;
            ferr      <= 1'b0;
            all_low   <= 1'b0;
            line_prev <= 1'b1;
            start_det <= 1'b0;
            push      <= 1'b0;
            char_out  <= '0;
        end else begin
            start_det <= 1'b0;
            push      <= 1'b0;
            if (tick) begin
                line_prev <= rx_s;
                unique case (state)
                    ST_IDLE: begin
                        if (line_prev && !rx_s) begin
                            state     <= ST_START;
                            tcnt      <= '0;
                            start_det <= 1'b1;
                        end
                    end
                    ST_START: begin
                        if (tcnt == MID_TICK) begin
                            tcnt    <= '0;
                            bitn    <= '0;
                            all_low <= 1'b1;
                            ferr    <= 1'b0;
                            state   <= rx_s ? ST_IDLE : ST_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (samp_pt) begin
                            tcnt    <= '0;
                            sh      <= {rx_s, sh[7:1]};
                            all_low <= low_n;
                            if (bitn == data_bits - 4'd1) begin
                                stop_left <= stop_count(stop_half);
                                state     <= parity_mode[0] ? ST_PAR : ST_STOP;
                            end else begin
                                bitn <= bitn + 4'd1;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (samp_pt) begin
                            tcnt    <= '0;
                            par_bit <= rx_s;
                            all_low <= low_n;
                            state   <= ST_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (samp_pt) begin
                            tcnt    <= '0;
                            ferr    <= ferr_n;
                            all_low <= low_n;
                            if (stop_left == 2'd1) begin
                                push          <= 1'b1;
                                state         <= ST_IDLE;
                                char_out.data <= aligned;
                                char_out.perr <= parity_mode[0] && (par_bit != par_exp);
                                char_out.ferr <= ferr_n;
                                char_out.brk  <= low_n;
                                char_out.ovr  <= 1'b0;
                            end else begin
                                stop_left <= stop_left - 2'd1;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R10: without an enable tick the sampler holds its position
    a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(state) && $stable(tcnt) && $stable(bitn)));

    // R8: a break character always carries a framing error
    a_r8_break_has_ferr: assert property (@(posedge clk) disable iff (rst)
        (push && char_out.brk) |-> char_out.ferr);
endmodule

// File: rtl/srx_queue.sv
`timescale 1ns/1ps
module srx_queue
    import srx_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          en,
    input  logic          push,
    input  rx_char_t      din,
    input  logic          pop,
    output rx_char_t      dout,
    output logic          empty,
    output logic [CW-1:0] count,
    output logic          err_any
);
    rx_char_t         mem [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic [CW-1:0]    cap;
    logic             full, do_pop, do_push, ovr_evt;
    logic [DEPTH-1:0] live_err;

    always_comb begin
        cap     = en ? CW'(DEPTH) : CW'(1);
        full    = (count >= cap);
        do_pop  = pop && (count != '0);
        do_push = push && (!full || do_pop);
        ovr_evt = push && full && !do_pop;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= wr_ptr + 1'b1;
            end else if (ovr_evt) begin
                mem[wr_ptr - PW'(1)].ovr <= 1'b1;
            end
            if (do_pop) rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_live
            logic [PW-1:0] off;
            always_comb begin
                off         = PW'(i) - rd_ptr;
                live_err[i] = ({1'b0, off} < count) &&
                              (mem[i].perr || mem[i].ferr || mem[i].brk || mem[i].ovr);
            end
        end
    endgenerate

    assign err_any = |live_err;
    assign empty   = (count == '0);
    assign dout    = mem[rd_ptr];

    // R6: occupancy never exceeds the storage
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R13: clear leaves nothing stored
    a_r13_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count == '0));

    // R7: an error can only be reported for stored data
    a_r7_err_needs_data: assert property (@(posedge clk) disable iff (rst)
        err_any |-> (count != '0));
endmodule

// File: rtl/serial_rx_core.sv
`timescale 1ns/1ps
module serial_rx_core
    import srx_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              rx_serial,
    input  logic [3:0]        data_bits,
    input  logic [2:0]        parity_mode,
    input  logic [2:0]        stop_half,
    input  logic              queue_en,
    input  logic              queue_clear,
    input  logic              rd_stb,
    output logic [7:0]        rd_data,
    output logic              rd_perr,
    output logic              rd_ferr,
    output logic              rd_brk,
    output logic              rd_ovr,
    output logic              empty,
    output logic [CW-1:0]     q_count,
    output logic              err_any,
    output logic [IDLE_W-1:0] idle_cnt,
    output logic              rx_timeout
);
    logic     rx_s, start_det, push;
    rx_char_t new_char, head;

    srx_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (rx_serial),
        .d_sync  (rx_s)
    );

    srx_framer u_framer (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick16),
        .rx_s        (rx_s),
        .data_bits   (data_bits),
        .parity_mode (parity_mode),
        .stop_half   (stop_half),
        .start_det   (start_det),
        .push        (push),
        .char_out    (new_char)
    );

    srx_queue #(.DEPTH(DEPTH)) u_queue (
        .clk     (clk),
        .rst     (rst),
        .clear   (queue_clear),
        .en      (queue_en),
        .push    (push),
        .din     (new_char),
        .pop     (rd_stb),
        .dout    (head),
        .empty   (empty),
        .count   (q_count),
        .err_any (err_any)
    );

    assign rd_data = head.data;
    assign rd_perr = head.perr;
    assign rd_ferr = head.ferr;
    assign rd_brk  = head.brk;
    assign rd_ovr  = head.ovr;

    always_ff @(posedge clk) begin
        if (rst)                      idle_cnt <= '0;
        else if (start_det || rd_stb) idle_cnt <= '0;
        else if (tick16)              idle_cnt <= idle_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rx_timeout <= 1'b0;
        else if (rd_stb)
            rx_timeout <= 1'b0;
        else if ((idle_cnt[IDLE_W-1:4] == idle_limit(data_bits)) && !empty)
            rx_timeout <= 1'b1;
    end

    // R11: a read always drops the timeout
    a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> !rx_timeout);

    // R12: no timeout can appear while nothing is stored
    a_r12_quiet_when_empty: assert property (@(posedge clk) disable iff (rst)
        (empty && !rx_timeout) |=> !rx_timeout);
endmodule

// File: tb/serial_rx_core_tb_top.sv
`timescale 1ns/1ps
module serial_rx_core_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rx_serial = 1'b1;
    logic [3:0] data_bits = 4'd8;
    logic [2:0] parity_mode = 3'b000;
    logic [2:0] stop_half = 3'd2;
    logic       queue_en = 1'b1;
    logic       queue_clear = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_brk, rd_ovr, empty, err_any, rx_timeout;
    logic [3:0] q_count;
    logic [9:0] idle_cnt;

    int checks = 0;
    int fails  = 0;
    int div    = 1;
    int tphase = 0;
    bit tick_hold = 1'b0;
    int cyc = 0;

    always #2 clk = ~clk;

    serial_rx_core dut_i (
        .clk(clk), .rst(rst), .tick16(tick16), .rx_serial(rx_serial),
        .data_bits(data_bits), .parity_mode(parity_mode), .stop_half(stop_half),
        .queue_en(queue_en), .queue_clear(queue_clear), .rd_stb(rd_stb),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
        .rd_ovr(rd_ovr), .empty(empty), .q_count(q_count), .err_any(err_any),
        .idle_cnt(idle_cnt), .rx_timeout(rx_timeout)
    );

    always @(negedge clk) begin
        if (tick_hold) begin
            tick16 = 1'b0;
        end else begin
            tick16 = (tphase == 0);
            tphase = (tphase + 1 >= div) ? 0 : tphase + 1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Fields: bits[19:16] parity[15:13] stop[12:10] data[9:2] bad_parity[1] bad_stop[0]
    localparam logic [19:0] VEC [0:7] = '{
        {4'd8, 3'b000, 3'd2, 8'hA5, 1'b0, 1'b0},
        {4'd8, 3'b001, 3'd2, 8'h3C, 1'b0, 1'b0},
        {4'd8, 3'b011, 3'd4, 8'h81, 1'b0, 1'b0},
        {4'd7, 3'b011, 3'd2, 8'h55, 1'b0, 1'b0},
        {4'd5, 3'b000, 3'd3, 8'h1F, 1'b0, 1'b0},
        {4'd6, 3'b101, 3'd4, 8'h2A, 1'b0, 1'b0},
        {4'd8, 3'b111, 3'd2, 8'hFF, 1'b1, 1'b0},
        {4'd8, 3'b000, 3'd2, 8'h96, 1'b0, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input logic [3:0] n);
        return 8'hFF >> (4'd8 - n);
    endfunction

    function automatic logic par_of(input logic [7:0] d, input logic [2:0] mode);
        case (mode)
            3'b001:  return ~(^d);
            3'b011:  return ^d;
            3'b101:  return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic hold_line(input logic v, input int ticks);
        rx_serial = v;
        repeat (ticks * div) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
        logic [7:0] m;
        m = d & mask_of(data_bits);
        hold_line(1'b0, 16);
        for (int i = 0; i < int'(data_bits); i++) hold_line(m[i], 16);
        if (parity_mode[0]) hold_line(par_of(m, parity_mode) ^ bad_par, 16);
        hold_line(~bad_stop, 16);
        if (stop_half == 3'd3) hold_line(1'b1, 8);
        if (stop_half == 3'd4) hold_line(1'b1, 16);
        hold_line(1'b1, 16);
        repeat (6) @(negedge clk);
    endtask

    task automatic read1;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(empty == 1'b1, "R1 empty after reset", empty, 1);
        chk(q_count == 4'd0, "R1 count after reset", q_count, 0);
        chk(err_any == 1'b0, "R1 err_any after reset", err_any, 0);
        chk(rx_timeout == 1'b0, "R1 timeout after reset", rx_timeout, 0);
        chk(idle_cnt <= 10'd2, "R1 idle counter after reset", idle_cnt, 0);

        // Format table: R2 data, R3 parity, R4 stop/framing
        for (int v = 0; v < 8; v++) begin
            logic [7:0] ed;
            data_bits   = VEC[v][19:16];
            parity_mode = VEC[v][15:13];
            stop_half   = VEC[v][12:10];
            ed = VEC[v][9:2] & mask_of(VEC[v][19:16]);
            send(VEC[v][9:2], VEC[v][1], VEC[v][0]);
            chk(q_count == 4'd1, "R6 one entry stored", q_count, 1);
            chk(rd_data == ed, "R2 received data", rd_data, ed);
            chk(rd_perr == VEC[v][1], "R3 parity flag", rd_perr, VEC[v][1]);
            chk(rd_ferr == VEC[v][0], "R4 framing flag", rd_ferr, VEC[v][0]);
            chk(rd_brk == 1'b0, "R8 no break on data", rd_brk, 0);
            read1();
            chk(empty == 1'b1, "R6 empty after read", empty, 1);
        end

        data_bits = 4'd8; parity_mode = 3'b000; stop_half = 3'd2;

        // R6 ordering and read on empty
        read1();
        chk(q_count == 4'd0, "R6 read while empty ignored", q_count, 0);
        send(8'h11, 0, 0); send(8'h22, 0, 0); send(8'h33, 0, 0);
        chk(q_count == 4'd3, "R6 count three", q_count, 3);
        chk(rd_data == 8'h11, "R6 first out", rd_data, 8'h11);
        read1();
        chk(rd_data == 8'h22, "R6 second out", rd_data, 8'h22);
        read1();
        chk(rd_data == 8'h33, "R6 third out", rd_data, 8'h33);
        read1();

        // R7 global error
        send(8'h44, 0, 0);
        parity_mode = 3'b011;
        send(8'h45, 1, 0);
        parity_mode = 3'b000;
        chk(err_any == 1'b1, "R7 error stored", err_any, 1);
        read1();
        chk(err_any == 1'b1, "R7 error still stored", err_any, 1);
        chk(rd_perr == 1'b1, "R3 flagged head", rd_perr, 1);
        read1();
        chk(err_any == 1'b0, "R7 error gone", err_any, 0);

        // R5 overrun in holding-register mode
        queue_en = 1'b0;
        send(8'h5A, 0, 0);
        chk(rd_ovr == 1'b0, "R5 no overrun yet", rd_ovr, 0);
        send(8'h6B, 0, 0);
        chk(q_count == 4'd1, "R5 capacity one", q_count, 1);
        chk(rd_data == 8'h5A, "R5 new byte dropped", rd_data, 8'h5A);
        chk(rd_ovr == 1'b1, "R5 overrun marked", rd_ovr, 1);
        chk(err_any == 1'b1, "R7 overrun counts", err_any, 1);
        read1();
        chk(empty == 1'b1, "R5 empty after read", empty, 1);
        queue_en = 1'b1;

        // R8 break
        send(8'h00, 0, 1);
        chk(rd_brk == 1'b1, "R8 break flagged", rd_brk, 1);
        chk(rd_ferr == 1'b1, "R8 break framing", rd_ferr, 1);
        read1();

        // R9 glitch shorter than half a bit
        hold_line(1'b0, 4);
        hold_line(1'b1, 200);
        chk(q_count == 4'd0, "R9 short low rejected", q_count, 0);

        // R10 tick gating
        begin
            logic [9:0] snap;
            @(negedge clk);
            tick_hold = 1'b1;
            @(negedge clk);
            snap = idle_cnt;
            hold_line(1'b0, 64);
            hold_line(1'b1, 64);
            chk(idle_cnt == snap, "R10 counter frozen", idle_cnt, snap);
            tick_hold = 1'b0;
            repeat (40) @(negedge clk);
            chk(q_count == 4'd0, "R10 no char without ticks", q_count, 0);
        end
        div = 2;
        send(8'hC3, 0, 0);
        chk(rd_data == 8'hC3, "R10 half-rate ticks", rd_data, 8'hC3);
        read1();
        div = 1;
        repeat (4) @(negedge clk);

        // R11 timeout, R12 quiet when empty
        send(8'h7E, 0, 0);
        repeat (480) @(negedge clk);
        chk(rx_timeout == 1'b0, "R11 not yet timed out", rx_timeout, 0);
        repeat (100) @(negedge clk);
        chk(rx_timeout == 1'b1, "R11 timeout raised", rx_timeout, 1);
        read1();
        chk(rx_timeout == 1'b0, "R11 read clears timeout", rx_timeout, 0);
        chk(idle_cnt <= 10'd2, "R11 read resets counter", idle_cnt, 0);
        repeat (1100) @(negedge clk);
        chk(rx_timeout == 1'b0, "R12 no timeout when empty", rx_timeout, 0);

        // R13 clear
        send(8'h01, 0, 0); send(8'h02, 0, 0);
        chk(q_count == 4'd2, "R13 two stored", q_count, 2);
        queue_clear = 1'b1;
        @(negedge clk);
        queue_clear = 1'b0;
        chk(q_count == 4'd0, "R13 count cleared", q_count, 0);
        chk(empty == 1'b1, "R13 empty after clear", empty, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule